// File: doc/BRIEF.md
# Configurable Flow/Pipe Channel Buffer

This block is a ready/valid queue for one decoupled channel of a bus interface. The payload is a fixed-width vector that the block never interprets. A bus-level wrapper places one instance on each channel. Each channel can take its own settings, or the wrapper can share one setting across all channels, or one per direction.

Three elaboration-time values shape the queue:
- **Depth.** The number of stored entries. A depth of zero turns the block into a straight connection.
- **Flow.** Lets an item offered to an empty queue appear at the output in the same cycle, so it can be consumed with no added latency. An item that takes this path is never written into storage.
- **Pipe.** Lets a full queue accept a new item in the same cycle it hands one out. A one-entry queue therefore keeps up with one transfer per cycle.

With both flags off, output valid and input ready come only from registered state. This breaks every combinational path across the channel.

Top module: `channel_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the queue is empty. With input valid low, output valid is low, and input ready is high whenever the depth is at least 1.
- R2: Items leave in exactly the order they were accepted, none lost and none repeated. An item is accepted when input valid and input ready are both high at a clock edge. It is delivered when output valid and output ready are both high.
- R3: With input ready and no dequeue, the queue accepts exactly DEPTH items. When not full, input ready is high.
- R4: Without flow, output valid is low while the queue is empty. An item accepted into an empty queue first shows at the output in the next cycle.
- R5: With flow and an empty queue, input valid and input data appear on the output in the same cycle. If that item is taken in that cycle, it is not stored, and the queue stays empty.
- R6: With pipe, a full queue whose output is being dequeued drives input ready high in that cycle. A depth-1 pipe queue sustains one transfer per cycle.
- R7: Without pipe, a full queue drives input ready low, whatever output ready is.
- R8: With depth 0, output valid equals input valid, input ready equals output ready, and output data equals input data, all in the same cycle.
- R9: While output valid is high and output ready is low with the queue non-empty, output valid stays high and output data stays unchanged in the next cycle.
- R10: With no parameters overridden, the block behaves as a depth-2 queue with flow and pipe both off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers an item |
| in_ready | output | 1 | Queue can take the offered item |
| in_data | input | WIDTH | Offered payload |
| out_valid | output | 1 | An item is available downstream |
| out_ready | input | 1 | Downstream takes the available item |
| out_data | output | WIDTH | Payload of the available item |

## Verification
The bench builds five instances side by side with an 8-bit payload:
- **Untouched defaults (depth 2).** Brings the R10 settings into reach.
- **Flow preset (depth 1).** Covers same-cycle bypass from an empty queue.
- **Pipe preset (depth 1).** Covers the full-and-draining case.
- **Depth 0.** Covers the straight connection.
- **Depth 3 with both flags on.** Covers bypass and pipe interacting with a non-power-of-two pointer wrap.

These depths are small, so fill, drain, back-to-back and a sweep of arithmetic valid/ready patterns reach every occupancy, including full, empty and wrap, many times over. The bench checks each cycle's ready, valid and data against a queue model computed from the requirements.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;

  // Bits needed to index a storage array of d entries.
  function automatic int chbuf_ptr_bits(input int d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

  // Bits needed to hold an occupancy from 0 up to d.
  function automatic int chbuf_cnt_bits(input int d);
    return (d > 0) ? $clog2(d + 1) : 1;
  endfunction

endpackage

// File: rtl/chbuf_mem.sv
module chbuf_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2,
  parameter int AW    = 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  // No reset on the array: entries are only read after being written.
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/chbuf_ctrl.sv
module chbuf_ctrl #(
  parameter int DEPTH = 2,
  parameter int AW    = 1,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          empty,
  output logic          full
);

  localparam logic [CW-1:0] LIMIT    = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [CW-1:0] occ;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= advance(wr_ptr);
      if (pop)  rd_ptr <= advance(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign empty = (occ == '0);
  assign full  = (occ == LIMIT);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> !full);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  assert_drain_step_R2: assert property (@(posedge clk) disable iff (rst)
    !push && pop |=> occ == $past(occ) - CW'(1));

  assert_fill_step_R3: assert property (@(posedge clk) disable iff (rst)
    push && !pop |=> !empty);

endmodule

// File: rtl/channel_buffer.sv
module channel_buffer
  import chbuf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2,
  parameter bit FLOW  = 1'b0,
  parameter bit PIPE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign out_valid = in_valid;
      assign in_ready  = out_ready;
      assign out_data  = in_data;
    end else begin : g_queue
      localparam int AW = chbuf_ptr_bits(DEPTH);
      localparam int CW = chbuf_cnt_bits(DEPTH);

      logic [AW-1:0]    wr_ptr, rd_ptr;
      logic             q_empty, q_full;
      logic             push, pop, bypass;
      logic [WIDTH-1:0] mem_rd;

      // Flow path: an item offered to an empty queue and taken at once skips storage.
      assign bypass    = FLOW && q_empty && in_valid && out_ready;
      assign out_valid = !q_empty || (FLOW && in_valid);
      assign out_data  = (FLOW && q_empty) ? in_data : mem_rd;

      // Pipe path: a full queue frees a slot in the same cycle it is drained.
      assign in_ready  = !q_full || (PIPE && out_ready);

      assign push = in_valid && in_ready && !bypass;
      assign pop  = out_ready && !q_empty;

      chbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .empty  (q_empty),
        .full   (q_full)
      );

      chbuf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (in_data),
        .raddr (rd_ptr),
        .rdata (mem_rd)
      );

      assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !q_empty |=> out_valid && $stable(out_data));

      if (FLOW) begin : g_flow_chk
        assert_flow_same_cycle_R5: assert property (@(posedge clk) disable iff (rst)
          q_empty && in_valid |-> out_valid && (out_data == in_data));
        assert_flow_not_stored_R5: assert property (@(posedge clk) disable iff (rst)
          q_empty && in_valid && out_ready |=> q_empty);
      end else begin : g_reg_chk
        assert_registered_valid_R4: assert property (@(posedge clk) disable iff (rst)
          q_empty |-> !out_valid);
      end

      if (PIPE) begin : g_pipe_chk
        assert_pipe_ready_R6: assert property (@(posedge clk) disable iff (rst)
          q_full && out_ready |-> in_ready);
      end else begin : g_nopipe_chk
        assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
          q_full |-> !in_ready);
      end
    end
  endgenerate

endmodule

// File: tb/chbuf_lane.sv
module chbuf_lane #(
  parameter int    W    = 8,
  parameter int    D    = 2,
  parameter bit    F    = 1'b0,
  parameter bit    P    = 1'b0,
  parameter bit    DEF  = 1'b0,
  parameter string NAME = "lane"
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   errors,
  output logic done
);

  logic         iv, ir, ov, ordy;
  logic [W-1:0] idata, odata;

  generate
    if (DEF) begin : g_def
      channel_buffer #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .in_valid(iv), .in_ready(ir), .in_data(idata),
        .out_valid(ov), .out_ready(ordy), .out_data(odata));
    end else begin : g_cfg
      channel_buffer #(.WIDTH(W), .DEPTH(D), .FLOW(F), .PIPE(P)) dut (
        .clk(clk), .rst(rst), .in_valid(iv), .in_ready(ir), .in_data(idata),
        .out_valid(ov), .out_ready(ordy), .out_data(odata));
    end
  endgenerate

  // Reference queue, computed from the requirements.
  int q [0:15];
  int m;
  int seq;
  bit held;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    string t;
    t = DEF ? {"R10+", tag} : tag;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s %s: actual %0d expected %0d", NAME, t, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic r);
    bit e_ir, e_ov, acc, tk;
    int e_od;
    string t_ir, t_ov, t_d;
    @(negedge clk);
    iv    = v;
    ordy  = r;
    idata = W'(seq);
    #1;
    if (D == 0) begin
      e_ir = r;
      t_ir = "R8";
    end else if (m < D) begin
      e_ir = 1'b1;
      t_ir = "R3";
    end else begin
      e_ir = P && r;
      t_ir = P ? "R6" : "R7";
    end
    e_ov = (m > 0) || ((F || D == 0) && v);
    e_od = (m > 0) ? q[0] : (seq % (1 << W));
    if (D == 0)      t_ov = "R8";
    else if (m == 0) t_ov = F ? "R5" : "R4";
    else             t_ov = "R2";
    t_d = held ? "R9" : ((D == 0) ? "R8" : ((m == 0) ? "R5" : "R2"));
    check(ir == e_ir, t_ir, "in_ready", int'(ir), int'(e_ir));
    check(ov == e_ov, t_ov, "out_valid", int'(ov), int'(e_ov));
    if (e_ov && ov) check(int'(odata) == e_od, t_d, "out_data", int'(odata), e_od);
    acc = v && e_ir;
    tk  = e_ov && r;
    if (acc) begin
      q[m] = seq % (1 << W);
      m++;
      seq++;
    end
    if (tk) begin
      for (int k = 0; k < 15; k++) q[k] = q[k+1];
      m--;
    end
    held = e_ov && !r && (m > 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    iv = 1'b0; ordy = 1'b0; idata = '0;
    m = 0; seq = 1; held = 1'b0;
    wait (rst == 1'b0);
    @(negedge clk);
    #1;
    check(ov == 1'b0, "R1", "out_valid after reset", int'(ov), 0);
    check(ir == (D > 0), "R1", "in_ready after reset", int'(ir), int'(D > 0));
    repeat (D + 3) step(1'b1, 1'b0);   // fill to capacity and beyond
    repeat (D + 3) step(1'b0, 1'b1);   // drain
    repeat (24)    step(1'b1, 1'b1);   // back-to-back
    for (int p = 0; p < 12; p++) begin
      for (int c = 0; c < 40; c++) begin
        step(((c * 13 + p * 7) % 5) < 3, ((c * 11 + p * 3) % 7) < 4);
      end
    end
    repeat (D + 4) step(1'b0, 1'b1);
    check(m == 0, "R2", "model drained", m, 0);
    done = 1'b1;
  end

endmodule

// File: tb/tb_channel_buffer.sv
module tb_channel_buffer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  int   c0, c1, c2, c3, c4;
  int   e0, e1, e2, e3, e4;
  logic d0, d1, d2, d3, d4;

  chbuf_lane #(.D(2), .F(1'b0), .P(1'b0), .DEF(1'b1), .NAME("default")) u_def (
    .clk(clk), .rst(rst), .checks(c0), .errors(e0), .done(d0));
  chbuf_lane #(.D(1), .F(1'b1), .P(1'b0), .NAME("flow1")) u_flow (
    .clk(clk), .rst(rst), .checks(c1), .errors(e1), .done(d1));
  chbuf_lane #(.D(1), .F(1'b0), .P(1'b1), .NAME("pipe1")) u_pipe (
    .clk(clk), .rst(rst), .checks(c2), .errors(e2), .done(d2));
  chbuf_lane #(.D(0), .F(1'b0), .P(1'b0), .NAME("wire")) u_wire (
    .clk(clk), .rst(rst), .checks(c3), .errors(e3), .done(d3));
  chbuf_lane #(.D(3), .F(1'b1), .P(1'b1), .NAME("both3")) u_both (
    .clk(clk), .rst(rst), .checks(c4), .errors(e4), .done(d4));

  initial begin
    int cyc;
    int tot_c, tot_e;
    cyc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (!(d0 && d1 && d2 && d3 && d4) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    tot_c = c0 + c1 + c2 + c3 + c4;
    tot_e = e0 + e1 + e2 + e3 + e4;
    if (!(d0 && d1 && d2 && d3 && d4)) begin
      tot_c++;
      tot_e++;
      $display("FAIL watchdog: actual timeout after %0d cycles, expected all lanes done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", tot_c, tot_e);
    $finish;
  end

endmodule